// File: doc/BRIEF.md
# Eight-Channel Pulse-Width Modulator with Pair Joining

This block produces eight independent pulse-width modulated outputs. Each channel runs an 8-bit up counter against a programmable period and compares it with a programmable duty value. The output sits at its active level while the count is below the duty value. A per-channel invert bit chooses whether that active level is high or low. Period and duty writes are held in a buffer until the channel's counter wraps, so a waveform never shows a half-updated cycle.

Counting is paced by one of four clock enables derived from the bus clock. Two plain enables, family A and family B, divide the bus clock by a programmable power of two. Two scaled enables then divide each plain enable by twice a programmable scale value. Channels whose index has bit 1 clear draw from family A; the others draw from family B. A per-channel select bit picks the plain or the scaled enable. Any even/odd channel pair can be joined into one 16-bit channel, and the odd pin then carries the joined waveform.

Software drives the block through a byte-wide register port. Writes are synchronous and reads are combinational.

Top module: `pwm_multi`

## Requirements
- R1: After reset every register, counter and output is 0. All eight outputs are low.
- R2: An enabled channel's counter advances by one on each cycle in which its selected clock enable is set. When it reaches period−1 it wraps to 0. A period of 0 holds the counter at 0.
- R3: The output is active while counter < duty. A duty of 0 gives a constant inactive output, and a duty of at least the period gives a constant active output.
- R4: Invert bit n (register 1, bit n) set to 0 makes the active level high; set to 1 it makes the active level low.
- R5: Clearing enable bit n (register 0, bit n) holds channel n's counter at 0 and drives its output to the inactive level, one cycle after the write.
- R6: Period (register 8+n) and duty (register 16+n) writes take effect when the counter wraps. While a channel is disabled, they take effect on the next cycle.
- R7: The plain enables come from a 7-bit free-running cycle counter that is cleared by reset. Enable A is set when the counter's low `a` bits are all ones, where `a` = register 4 bits [2:0]. Enable B uses `b` = register 4 bits [6:4] in the same way. A setting of 0 sets the enable every cycle.
- R8: A scaled enable fires on every (2×s)-th plain enable, where s is register 5 (family A) or register 6 (family B), and s = 0 counts as 256. Select bit n (register 2, bit n) set to 1 picks the scaled enable.
- R9: Bit k of register 3 joins channels 2k and 2k+1. The odd channel holds the high byte of the counter, period and duty, and the even channel holds the low byte. The odd channel's enable, select and invert bits govern the joined channel. The odd pin carries the waveform, and the even pin is held low.
- R10: Registers 0–6 and 8–23 read back their stored values. Unused bits read 0, and address 7 reads 0. Address 24+n returns channel n's counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | 5 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| pwmOut | output | 8 | Modulated outputs, bit n for channel n |

## Verification
The case that needs most care is a period or duty write that falls in the same cycle as a counter wrap, which is also the cycle when the buffered values are loaded. The bench provokes this by rewriting period and duty while the channels are free-running. It does the same during the prescale and scale changes, so that writes land at arbitrary counter phases, including on wrap edges. A behavioural model steps the counters with integer arithmetic and applies each register write only after computing that cycle's step. Every cycle the model's eight outputs are compared with the pins, so taking the new value one cycle early or late shows up as a mismatch.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DATA_W     = 8;
  localparam int NUM_PAIRS  = 4;
  localparam int NUM_CH     = 2 * NUM_PAIRS;
  localparam int ADDR_W     = 5;
  localparam int PRE_W      = 3;
  localparam int PRE_CNT_W  = (1 << PRE_W) - 1;
  localparam int SCL_CNT_W  = DATA_W + 2;
  localparam int NUM_FAM    = 2;

  localparam logic [ADDR_W-1:0] A_EN      = 5'd0;
  localparam logic [ADDR_W-1:0] A_INV     = 5'd1;
  localparam logic [ADDR_W-1:0] A_SEL     = 5'd2;
  localparam logic [ADDR_W-1:0] A_JOIN    = 5'd3;
  localparam logic [ADDR_W-1:0] A_PRE     = 5'd4;
  localparam logic [ADDR_W-1:0] A_SCALE_A = 5'd5;
  localparam logic [ADDR_W-1:0] A_SCALE_B = 5'd6;

  typedef struct packed {
    logic tickA;
    logic tickSA;
    logic tickB;
    logic tickSB;
  } clkStrobes_t;
endpackage

// File: rtl/pwm_pair.sv
module pwm_pair import pwm_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickE,
  input  logic              tickO,
  input  logic              enE,
  input  logic              enO,
  input  logic              invE,
  input  logic              invO,
  input  logic              wide,
  input  logic [DATA_W-1:0] perE,
  input  logic [DATA_W-1:0] perO,
  input  logic [DATA_W-1:0] dutyE,
  input  logic [DATA_W-1:0] dutyO,
  output logic [DATA_W-1:0] cntE,
  output logic [DATA_W-1:0] cntO,
  output logic              outE,
  output logic              outO
);
  localparam int WIDE_W = 2 * DATA_W;

  logic [DATA_W-1:0] apE, apO, adE, adO;
  logic [WIDE_W-1:0] cnt16, per16, duty16;
  logic wrapE, wrapO, wrap16;

  assign cnt16  = {cntO, cntE};
  assign per16  = {apO, apE};
  assign duty16 = {adO, adE};

  assign wrapE  = (apE == '0) || (cntE >= apE - 1'b1);
  assign wrapO  = (apO == '0) || (cntO >= apO - 1'b1);
  assign wrap16 = (per16 == '0) || (cnt16 >= per16 - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntE <= '0; cntO <= '0;
      apE  <= '0; apO  <= '0;
      adE  <= '0; adO  <= '0;
    end else if (wide) begin
      if (!enO || (tickO && wrap16)) begin
        cntE <= '0; cntO <= '0;
        apE  <= perE; apO <= perO;
        adE  <= dutyE; adO <= dutyO;
      end else if (tickO) begin
        {cntO, cntE} <= cnt16 + 1'b1;
      end
    end else begin
      if (!enE || (tickE && wrapE)) begin
        cntE <= '0; apE <= perE; adE <= dutyE;
      end else if (tickE) begin
        cntE <= cntE + 1'b1;
      end
      if (!enO || (tickO && wrapO)) begin
        cntO <= '0; apO <= perO; adO <= dutyO;
      end else if (tickO) begin
        cntO <= cntO + 1'b1;
      end
    end
  end

  assign outE = wide ? 1'b0 : (invE ^ (enE && (cntE < adE)));
  assign outO = invO ^ (enO && (wide ? (cnt16 < duty16) : (cntO < adO)));

  // R2: narrow counter never reaches its buffered period
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!wide) |-> ((apE == '0) ? (cntE == '0) : (cntE < apE)));

  // R2: no clock enable, no movement
  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!wide && enE && $past(!wide && enE && !tickE)) |-> $stable(cntE));

  // R6: buffered values only change on the cycle the counter returns to 0
  p_buffer_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!wide && enE && cntE != '0) |-> ($stable(apE) && $stable(adE)));

  // R3: zero duty keeps the pin at its inactive level
  p_duty_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!wide && adE == '0) |-> (outE == invE));

  // R9: even pin quiet while joined
  p_even_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    wide |-> !outE);
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl import pwm_pkg::*; (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wrData,
  output logic [DATA_W-1:0]            rdData,
  input  logic [NUM_CH-1:0][DATA_W-1:0] chCnt,
  output logic [NUM_CH-1:0]            enVec,
  output logic [NUM_CH-1:0]            invVec,
  output logic [NUM_CH-1:0]            selVec,
  output logic [NUM_PAIRS-1:0]         joinVec,
  output logic [NUM_CH-1:0][DATA_W-1:0] perArr,
  output logic [NUM_CH-1:0][DATA_W-1:0] dutyArr,
  output clkStrobes_t                  strobes
);
  localparam logic [SCL_CNT_W-1:0] SCL_MAX = SCL_CNT_W'((2 ** (DATA_W + 1)) - 1);
  localparam int CH_IDX_W = $clog2(NUM_CH);

  logic [PRE_W-1:0]     preExp   [NUM_FAM];
  logic [DATA_W-1:0]    scaleReg [NUM_FAM];
  logic [PRE_CNT_W-1:0] preCnt;
  logic [NUM_FAM-1:0]   tickPlain, tickScaled;

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enVec <= '0; invVec <= '0; selVec <= '0; joinVec <= '0;
      perArr <= '0; dutyArr <= '0;
      for (int f = 0; f < NUM_FAM; f++) begin
        preExp[f] <= '0;
        scaleReg[f] <= '0;
      end
    end else if (wrEn) begin
      case (addr)
        A_EN:      enVec   <= wrData;
        A_INV:     invVec  <= wrData;
        A_SEL:     selVec  <= wrData;
        A_JOIN:    joinVec <= wrData[NUM_PAIRS-1:0];
        A_PRE: begin
          preExp[0] <= wrData[PRE_W-1:0];
          preExp[1] <= wrData[PRE_W+3:4];
        end
        A_SCALE_A: scaleReg[0] <= wrData;
        A_SCALE_B: scaleReg[1] <= wrData;
        default: begin
          if (addr[ADDR_W-1:3] == 2'd1) perArr[addr[CH_IDX_W-1:0]]  <= wrData;
          if (addr[ADDR_W-1:3] == 2'd2) dutyArr[addr[CH_IDX_W-1:0]] <= wrData;
        end
      endcase
    end
  end

  // read mux
  always_comb begin
    rdData = '0;
    case (addr)
      A_EN:      rdData = enVec;
      A_INV:     rdData = invVec;
      A_SEL:     rdData = selVec;
      A_JOIN:    rdData = {{(DATA_W-NUM_PAIRS){1'b0}}, joinVec};
      A_PRE:     rdData = {1'b0, preExp[1], 1'b0, preExp[0]};
      A_SCALE_A: rdData = scaleReg[0];
      A_SCALE_B: rdData = scaleReg[1];
      default: begin
        case (addr[ADDR_W-1:3])
          2'd1:    rdData = perArr[addr[CH_IDX_W-1:0]];
          2'd2:    rdData = dutyArr[addr[CH_IDX_W-1:0]];
          2'd3:    rdData = chCnt[addr[CH_IDX_W-1:0]];
          default: rdData = '0;
        endcase
      end
    endcase
  end

  // shared prescale counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  // one plain and one scaled enable per family
  for (genvar f = 0; f < NUM_FAM; f++) begin : g_fam
    logic [PRE_CNT_W-1:0] mask;
    logic [SCL_CNT_W-1:0] limit;
    logic [SCL_CNT_W-1:0] sclCnt;

    assign mask  = ~({PRE_CNT_W{1'b1}} << preExp[f]);
    assign limit = (scaleReg[f] == '0) ? SCL_MAX
                 : ({1'b0, scaleReg[f], 1'b0} - 1'b1);
    assign tickPlain[f]  = ((preCnt & mask) == mask);
    assign tickScaled[f] = tickPlain[f] && (sclCnt >= limit);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              sclCnt <= '0;
      else if (tickScaled[f]) sclCnt <= '0;
      else if (tickPlain[f])  sclCnt <= sclCnt + 1'b1;
    end
  end

  assign strobes.tickA  = tickPlain[0];
  assign strobes.tickSA = tickScaled[0];
  assign strobes.tickB  = tickPlain[1];
  assign strobes.tickSB = tickScaled[1];

  // R10: a write to the family-A scale register lands on the next cycle
  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_SCALE_A) |=> (scaleReg[0] == $past(wrData)));
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath import pwm_pkg::*; (
  input  logic                          clk,
  input  logic                          rstN,
  input  clkStrobes_t                   strobes,
  input  logic [NUM_CH-1:0]             enVec,
  input  logic [NUM_CH-1:0]             invVec,
  input  logic [NUM_CH-1:0]             selVec,
  input  logic [NUM_PAIRS-1:0]          joinVec,
  input  logic [NUM_CH-1:0][DATA_W-1:0] perArr,
  input  logic [NUM_CH-1:0][DATA_W-1:0] dutyArr,
  output logic [NUM_CH-1:0][DATA_W-1:0] chCnt,
  output logic [NUM_CH-1:0]             pwmOut
);
  logic [NUM_CH-1:0] chTick;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_tick
    localparam bit FAM_B = ((c >> 1) & 1) == 1;
    if (FAM_B) begin : g_b
      assign chTick[c] = selVec[c] ? strobes.tickSB : strobes.tickB;
    end else begin : g_a
      assign chTick[c] = selVec[c] ? strobes.tickSA : strobes.tickA;
    end
  end

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    pwm_pair u_pair (
      .clk   (clk),
      .rstN  (rstN),
      .tickE (chTick[2*k]),
      .tickO (chTick[2*k+1]),
      .enE   (enVec[2*k]),
      .enO   (enVec[2*k+1]),
      .invE  (invVec[2*k]),
      .invO  (invVec[2*k+1]),
      .wide  (joinVec[k]),
      .perE  (perArr[2*k]),
      .perO  (perArr[2*k+1]),
      .dutyE (dutyArr[2*k]),
      .dutyO (dutyArr[2*k+1]),
      .cntE  (chCnt[2*k]),
      .cntO  (chCnt[2*k+1]),
      .outE  (pwmOut[2*k]),
      .outO  (pwmOut[2*k+1])
    );
  end
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi import pwm_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  clkStrobes_t                   strobes;
  logic [NUM_CH-1:0]             enVec, invVec, selVec;
  logic [NUM_PAIRS-1:0]          joinVec;
  logic [NUM_CH-1:0][DATA_W-1:0] perArr, dutyArr, chCnt;

  pwm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .chCnt(chCnt), .enVec(enVec), .invVec(invVec),
    .selVec(selVec), .joinVec(joinVec), .perArr(perArr), .dutyArr(dutyArr),
    .strobes(strobes)
  );

  pwm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .enVec(enVec), .invVec(invVec),
    .selVec(selVec), .joinVec(joinVec), .perArr(perArr), .dutyArr(dutyArr),
    .chCnt(chCnt), .pwmOut(pwmOut)
  );
endmodule

// File: tb/tb_pwm_multi.sv
`timescale 1ns/1ps
module tb_pwm_multi;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] pwmOut;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  pwm_multi dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
                 .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut));

  // behavioural reference
  int pre, sc[2], pe[2], scl[2];
  int en, inv, sel, cat;
  int per[8], dut_[8], cnt[8], ap[8], ad[8];
  bit tp[2], ts[2];

  function automatic bit chTick(int ch);
    int g = (ch >> 1) & 1;
    return ((sel >> ch) & 1) ? ts[g] : tp[g];
  endfunction

  function automatic bit bitOf(int v, int n);
    return ((v >> n) & 1) == 1;
  endfunction

  function automatic void load(int ch);
    cnt[ch] = 0; ap[ch] = per[ch]; ad[ch] = dut_[ch];
  endfunction

  function automatic void modelStep();
    for (int g = 0; g < 2; g++) begin
      int m = (1 << pe[g]) - 1;
      int lim = (scl[g] == 0) ? 511 : 2 * scl[g] - 1;
      tp[g] = ((pre & m) == m);
      ts[g] = 0;
      if (tp[g]) begin
        if (sc[g] >= lim) begin ts[g] = 1; sc[g] = 0; end
        else sc[g]++;
      end
    end
    pre = (pre + 1) % 128;
    for (int k = 0; k < 4; k++) begin
      int e = 2 * k;
      int o = e + 1;
      if (bitOf(cat, k)) begin
        bit tk = chTick(o);
        int c16 = cnt[o] * 256 + cnt[e];
        int p16 = ap[o] * 256 + ap[e];
        if (!bitOf(en, o) || (tk && (p16 == 0 || c16 >= p16 - 1))) begin
          load(e); load(o);
        end else if (tk) begin
          c16++;
          cnt[o] = c16 >> 8; cnt[e] = c16 & 255;
        end
      end else begin
        for (int ch = e; ch <= o; ch++) begin
          bit tk = chTick(ch);
          if (!bitOf(en, ch) || (tk && (ap[ch] == 0 || cnt[ch] >= ap[ch] - 1))) load(ch);
          else if (tk) cnt[ch]++;
        end
      end
    end
  endfunction

  function automatic void modelWrite(int a, int d);
    case (a)
      0: en = d;
      1: inv = d;
      2: sel = d;
      3: cat = d & 15;
      4: begin pe[0] = d & 7; pe[1] = (d >> 4) & 7; end
      5: scl[0] = d;
      6: scl[1] = d;
      default: begin
        if (a >= 8 && a < 16) per[a-8] = d;
        else if (a >= 16 && a < 24) dut_[a-16] = d;
      end
    endcase
  endfunction

  function automatic int modelRead(int a);
    case (a)
      0: return en;
      1: return inv;
      2: return sel;
      3: return cat;
      4: return (pe[1] << 4) | pe[0];
      5: return scl[0];
      6: return scl[1];
      default: begin
        if (a >= 8 && a < 16) return per[a-8];
        if (a >= 16 && a < 24) return dut_[a-16];
        if (a >= 24) return cnt[a-24];
        return 0;
      end
    endcase
  endfunction

  function automatic logic [7:0] modelOut();
    logic [7:0] r;
    for (int ch = 0; ch < 8; ch++) begin
      int k = ch >> 1;
      bit act;
      if (bitOf(cat, k)) begin
        if ((ch & 1) == 0) begin r[ch] = 1'b0; continue; end
        act = bitOf(en, ch) &&
              ((cnt[ch] * 256 + cnt[ch-1]) < (ad[ch] * 256 + ad[ch-1]));
      end else begin
        act = bitOf(en, ch) && (cnt[ch] < ad[ch]);
      end
      r[ch] = bitOf(inv, ch) ^ act;
    end
    return r;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre = 0; en = 0; inv = 0; sel = 0; cat = 0;
      for (int g = 0; g < 2; g++) begin sc[g] = 0; pe[g] = 0; scl[g] = 0; end
      for (int c = 0; c < 8; c++) begin
        per[c] = 0; dut_[c] = 0; cnt[c] = 0; ap[c] = 0; ad[c] = 0;
      end
    end else begin
      modelStep();
      if (wrEn) modelWrite(int'(addr), int'(wrData));
    end
  end

  // per-cycle output comparison
  always @(negedge clk) begin
    if (!done) begin
      logic [7:0] exp;
      exp = modelOut();
      compared++;
      if (pwmOut !== exp) begin
        mismatched++;
        $display("FAIL %s: pwmOut actual %b expected %b at %0t", curReq, pwmOut, exp, $time);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; addr = 5'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input int a, input string req);
    @(negedge clk);
    addr = 5'(a);
    #1;
    compared++;
    if (int'(rdData) != modelRead(a)) begin
      mismatched++;
      $display("FAIL %s: read addr %0d actual %0d expected %0d", req, a, rdData, modelRead(a));
    end
  endtask

  task automatic finish();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    finish();
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    rdChk(0, "R1"); rdChk(4, "R1"); rdChk(8, "R1"); rdChk(24, "R1");

    // R2: basic counting and wrap, channel 0 on plain A every cycle
    curReq = "R2";
    wr(8, 10); wr(16, 3); wr(0, 8'h01);
    repeat (40) @(negedge clk);

    // R3: zero duty on ch1, duty above period on ch2 (family B)
    curReq = "R3";
    wr(9, 8); wr(17, 0); wr(10, 8); wr(18, 20); wr(0, 8'h07);
    repeat (40) @(negedge clk);

    // R4: inverted channel 3
    curReq = "R4";
    wr(11, 6); wr(19, 2); wr(1, 8'h08); wr(0, 8'h0F);
    repeat (30) @(negedge clk);

    // R6: rewrite period and duty while running; may coincide with a wrap
    curReq = "R6";
    wr(8, 5); wr(16, 4); wr(11, 4); wr(19, 3);
    repeat (30) @(negedge clk);
    rdChk(24, "R6");

    // R7: prescale A by 4, B by 8
    curReq = "R7";
    wr(4, 8'h32);
    repeat (200) @(negedge clk);
    wr(10, 5); wr(18, 2);
    repeat (100) @(negedge clk);

    // R8: scaled A (scale 3) on ch4, scaled B (scale 0 = 256) on ch6
    curReq = "R8";
    wr(4, 8'h02); wr(5, 3); wr(6, 0);
    wr(12, 4); wr(20, 2); wr(14, 3); wr(22, 1);
    wr(2, 8'h50); wr(0, 8'h5F);
    repeat (3500) @(negedge clk);
    rdChk(28, "R8"); rdChk(30, "R8");

    // R9: join channels 6 and 7 into one 16-bit channel
    curReq = "R9";
    wr(0, 8'h0F); wr(3, 8'h08); wr(2, 8'h00); wr(4, 8'h00);
    wr(14, 8'h30); wr(15, 8'h01); wr(22, 8'h90); wr(23, 8'h00);
    wr(0, 8'hCF);
    repeat (700) @(negedge clk);
    rdChk(30, "R9"); rdChk(31, "R9");

    // R5: disable channel 0 mid-run
    curReq = "R5";
    wr(0, 8'hCE);
    repeat (20) @(negedge clk);
    rdChk(24, "R5");

    // R10: full register readback
    curReq = "R10";
    for (int a = 0; a < 32; a++) rdChk(a, "R10");
    repeat (5) @(negedge clk);
    finish();
  end
endmodule